// File: doc/BRIEF.md
# Decimal Digit Adder with Look-Ahead Carry

This block adds two packed decimal digits and an incoming carry in one combinational pass. It does not run a four-bit binary sum and then a separate correction stage that adds six. It forms generate, propagate and half-sum terms for every bit. From the three upper bit pairs it derives a group carry-generate and a group carry-propagate term. It takes the carry out of the ones position from bit 0 alone. The sum digit and the decimal carry then come from closed-form equations over those terms.

The logic sits in three layers: per-bit terms, group terms, and the sum and carry equations. Each sum bit above bit 0 selects between two expressions, and the carry from the ones position picks which one applies. Where two product terms can never be true together for valid digits, they are joined by XOR instead of OR. One copy of the block handles one decimal digit. A wider adder chains copies by linking carry_out to the next carry_in.

Top module: `cla_bcd_digit_adder`

## Requirements
- R1: For every digit pair a_dig, b_dig in 0..9 and either carry_in, sum_dig equals (a_dig + b_dig + carry_in) mod 10, and carry_out is 1 exactly when that total is 10 or more.
- R2: sum_dig[0] equals a_dig[0] XOR b_dig[0] XOR carry_in, whatever the upper bits are.
- R3: When the upper parts a_dig[3:1] + b_dig[3:1] (as integers) total 5 or more, carry_out is 1 regardless of a_dig[0], b_dig[0] and carry_in.
- R4: When the upper parts total exactly 4, carry_out equals the ones-position carry, a_dig[0]&b_dig[0] | (a_dig[0]|b_dig[0])&carry_in.
- R5: When the upper parts total 3 or less, carry_out is 0.
- R6: sum_dig is always a valid decimal digit (0..9) for valid inputs.
- R7: Swapping a_dig and b_dig leaves sum_dig and carry_out unchanged.
- R8: The block holds no state: its outputs depend only on the present inputs, with no clock and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_dig | input | 4 | First addend digit, 0..9 |
| b_dig | input | 4 | Second addend digit, 0..9 |
| carry_in | input | 1 | Incoming decimal carry |
| sum_dig | output | 4 | Decimal sum digit |
| carry_out | output | 1 | Outgoing decimal carry |

## Verification
The equations depend on valid digits. A digit with bit 3 set has zero in bits 2 and 1, so each upper part lies in 0..4. The embedded assertions therefore check only while both addends are 9 or less, and they ignore other codes. The bench drives only digits from 0 to 9. It uses a table of chosen pairs, a sweep of all 200 valid combinations, and sweeps sorted by the upper-part total, so every input it applies keeps within that assumption.

// File: rtl/cla_bcd_pkg.sv
// Package: shared widths and term bundles for the decimal digit adder.
// Assumes one packed decimal digit of four bits.
package cla_bcd_pkg;
    localparam int DIGIT_W = 4;
    localparam int UPPER_W = DIGIT_W - 1;
    localparam int RADIX   = 10;

    // generate / propagate / half-sum for one bit position
    typedef struct packed {
        logic g;
        logic p;
        logic h;
    } bit_term_t;

    // group carry terms over bits 3..1 plus the ones-position carry
    typedef struct packed {
        logic k;
        logic l;
        logic c1;
    } group_term_t;
endpackage

// File: rtl/cla_bcd_bit_terms.sv
// Module: layer one, per-bit generate, propagate and half-sum terms.
// Assumes nothing about the inputs; purely combinational.
module cla_bcd_bit_terms
    import cla_bcd_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    output bit_term_t [W-1:0] terms
);
    for (genvar j = 0; j < W; j++) begin : g_bit
        // purpose: form the three terms of bit j
        always_comb begin
            terms[j].g = x[j] & y[j];
            terms[j].p = x[j] | y[j];
            terms[j].h = x[j] ^ y[j];
        end
    end
endmodule

// File: rtl/cla_bcd_group.sv
// Module: layer two, group carry-generate (k) and carry-propagate (l)
// over the upper bit pairs, plus the carry out of the ones position.
// Assumes valid digits: an operand with bit 3 set has bits 2 and 1 clear.
module cla_bcd_group
    import cla_bcd_pkg::*;
(
    input  bit_term_t [DIGIT_W-1:0] terms,
    input  logic                    cin,
    output group_term_t             grp
);
    logic g1, g2, g3, p1, p2, p3, h1, h2, h3;

    // purpose: unpack the upper-bit terms for readability
    always_comb begin
        g1 = terms[1].g; g2 = terms[2].g; g3 = terms[3].g;
        p1 = terms[1].p; p2 = terms[2].p; p3 = terms[3].p;
        h1 = terms[1].h; h2 = terms[2].h; h3 = terms[3].h;
    end

    // purpose: upper-part total >= 5 (k) and == 4 (l); ones carry (c1)
    always_comb begin
        grp.k  = g3 | (p3 & p2) | (p3 & p1) | (g2 & p1);
        grp.l  = (~p3 & ((g2 & ~p1) ^ (g1 & h2))) | (h3 & ~p2 & ~p1);
        grp.c1 = terms[0].g | (terms[0].p & cin);
    end
endmodule

// File: rtl/cla_bcd_sum_sel.sv
// Module: layer three, sum bits and decimal carry.
// Bits 3..1 each pick one of two expressions by the ones carry.
// Assumes valid digits, so the upper-part total lies in 0..8.
module cla_bcd_sum_sel
    import cla_bcd_pkg::*;
(
    input  bit_term_t [DIGIT_W-1:0] terms,
    input  group_term_t             grp,
    input  logic                    cin,
    output logic [DIGIT_W-1:0]      sum,
    output logic                    cout
);
    logic g1, g2, g3, p1, p2, p3, h1, h2, h3;
    logic u1, u2, u3, u6, u7, u8;

    // purpose: unpack the upper-bit terms
    always_comb begin
        g1 = terms[1].g; g2 = terms[2].g; g3 = terms[3].g;
        p1 = terms[1].p; p2 = terms[2].p; p3 = terms[3].p;
        h1 = terms[1].h; h2 = terms[2].h; h3 = terms[3].h;
    end

    // purpose: one-hot detectors of the upper-part total (1,2,3,6,7,8)
    always_comb begin
        u1 = ~p3 & ~p2 & h1;
        u2 = ~p3 & ((g1 & ~p2) ^ (h2 & ~p1));
        u3 = ~p3 & h2 & h1;
        u6 = (h3 & h2 & ~p1) ^ (g2 & g1);
        u7 = h3 & h2 & h1;
        u8 = g3;
    end

    // purpose: select each upper sum bit by the ones carry
    always_comb begin
        sum[0] = terms[0].h ^ cin;
        if (grp.c1) begin
            sum[1] = ~(h1 ^ grp.k ^ grp.l);
            sum[2] = u1 ^ u2 ^ u6 ^ u7;
            sum[3] = u8 ^ u3;
        end else begin
            sum[1] = h1 ^ grp.k;
            sum[2] = u2 ^ u3 ^ u7 ^ u8;
            sum[3] = grp.l;
        end
    end

    // purpose: decimal carry; k and l never hold together, so XOR is safe
    always_comb cout = grp.k ^ (grp.l & grp.c1);
endmodule

// File: rtl/cla_bcd_digit_adder.sv
// Module: top of the single-digit decimal adder with look-ahead carry.
// Assumes both addends are 0..9; other codes give undefined results.
// Purely combinational: no clock, no reset, no state.
module cla_bcd_digit_adder
    import cla_bcd_pkg::*;
(
    input  logic [3:0] a_dig,
    input  logic [3:0] b_dig,
    input  logic       carry_in,
    output logic [3:0] sum_dig,
    output logic       carry_out
);
    bit_term_t [DIGIT_W-1:0] terms;
    group_term_t             grp;

    cla_bcd_bit_terms #(.W(DIGIT_W)) u_terms (
        .x     (a_dig),
        .y     (b_dig),
        .terms (terms)
    );

    cla_bcd_group u_group (
        .terms (terms),
        .cin   (carry_in),
        .grp   (grp)
    );

    cla_bcd_sum_sel u_sum (
        .terms (terms),
        .grp   (grp),
        .cin   (carry_in),
        .sum   (sum_dig),
        .cout  (carry_out)
    );

    logic       in_valid;
    logic [4:0] total;
    logic [3:0] upper_tot;

    // purpose: reference quantities for the embedded checks
    always_comb begin
        in_valid  = (a_dig <= 4'd9) && (b_dig <= 4'd9);
        total     = {1'b0, a_dig} + {1'b0, b_dig} + {4'b0, carry_in};
        upper_tot = {1'b0, a_dig[3:1]} + {1'b0, b_dig[3:1]};
    end

    // purpose: guard the group terms and the outputs against arithmetic
    always_comb begin
        if (in_valid) begin
            p_group_excl_r3: assert (!(grp.k && grp.l));
            p_group_gen_r3: assert (grp.k == (upper_tot >= 4'd5));
            p_group_prop_r4: assert (grp.l == (upper_tot == 4'd4));
            p_digit_range_r6: assert (sum_dig <= 4'd9);
            p_carry_value_r1: assert (carry_out == (total >= 5'd10));
            p_sum_value_r1: assert ({1'b0, sum_dig} ==
                                    (carry_out ? total - 5'd10 : total));
        end
    end
endmodule

// File: tb/test_cla_bcd_digit_adder.sv
module test_cla_bcd_digit_adder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;
    localparam int NVEC = 16;

    // entry: {a[3:0], b[3:0], cin, sum[3:0], cout}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd0, 4'd0, 1'b0, 4'd0, 1'b0},
        {4'd9, 4'd9, 1'b1, 4'd9, 1'b1},
        {4'd9, 4'd9, 1'b0, 4'd8, 1'b1},
        {4'd5, 4'd5, 1'b0, 4'd0, 1'b1},
        {4'd4, 4'd5, 1'b0, 4'd9, 1'b0},
        {4'd4, 4'd5, 1'b1, 4'd0, 1'b1},
        {4'd8, 4'd1, 1'b0, 4'd9, 1'b0},
        {4'd8, 4'd1, 1'b1, 4'd0, 1'b1},
        {4'd7, 4'd3, 1'b0, 4'd0, 1'b1},
        {4'd2, 4'd2, 1'b1, 4'd5, 1'b0},
        {4'd6, 4'd3, 1'b1, 4'd0, 1'b1},
        {4'd3, 4'd3, 1'b0, 4'd6, 1'b0},
        {4'd9, 4'd0, 1'b1, 4'd0, 1'b1},
        {4'd1, 4'd8, 1'b0, 4'd9, 1'b0},
        {4'd5, 4'd4, 1'b1, 4'd0, 1'b1},
        {4'd7, 4'd7, 1'b1, 4'd5, 1'b1}
    };

    logic       clk = 1'b0;
    logic [3:0] a_dig = 4'd0;
    logic [3:0] b_dig = 4'd0;
    logic       carry_in = 1'b0;
    logic [3:0] sum_dig;
    logic       carry_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    cla_bcd_digit_adder i_cla_bcd_digit_adder (
        .a_dig     (a_dig),
        .b_dig     (b_dig),
        .carry_in  (carry_in),
        .sum_dig   (sum_dig),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, a_dig, b_dig, carry_in, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int c);
        a_dig = 4'(a); b_dig = 4'(b); carry_in = 1'(c);
        #1;
    endtask

    initial begin
        // R8: outputs at the all-zero input with no clock edge taken
        #1;
        check("R8 idle", {carry_out, sum_dig}, 5'd0);

        // R1: table of chosen vectors
        for (int i = 0; i < NVEC; i++) begin
            apply(int'(VEC[i][13:10]), int'(VEC[i][9:6]), int'(VEC[i][5]));
            check("R1 table", {carry_out, sum_dig}, {VEC[i][0], VEC[i][4:1]});
        end

        // R1, R2, R6, R7: every valid combination
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 2; c++) begin
                    int t;
                    logic [4:0] first;
                    t = a + b + c;
                    apply(a, b, c);
                    check("R1 sweep", {carry_out, sum_dig}, {1'(t >= 10), 4'(t % 10)});
                    check("R2 lsb", {4'd0, sum_dig[0]}, {4'd0, 1'(t % 2)});
                    check("R6 range", {4'd0, 1'(sum_dig <= 4'd9)}, 5'd1);
                    first = {carry_out, sum_dig};
                    apply(b, a, c);
                    check("R7 swap", {carry_out, sum_dig}, first);
                end

        // R3, R4, R5: carry classified by the upper-part total
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 2; c++) begin
                    int up, c1;
                    up = a / 2 + b / 2;
                    c1 = ((a % 2) + (b % 2) + c) >= 2 ? 1 : 0;
                    apply(a, b, c);
                    if (up >= 5)
                        check("R3 group gen", {4'd0, carry_out}, 5'd1);
                    else if (up == 4)
                        check("R4 group prop", {4'd0, carry_out}, 5'(c1));
                    else
                        check("R5 no carry", {4'd0, carry_out}, 5'd0);
                end

        // R8: outputs follow inputs again after clock edges pass
        apply(9, 9, 1);
        repeat (3) @(posedge clk);
        #1;
        check("R8 hold", {carry_out, sum_dig}, {1'b1, 4'd9});
        apply(0, 0, 0);
        check("R8 return", {carry_out, sum_dig}, 5'd0);

        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < WATCHDOG_CYCLES) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule